// File: doc/BRIEF.md
# Multi-Source Reset Domain Controller

This block merges three reset causes into the reset signals of a controller chip. The causes are a cold platform reset pin, a warm reset pin and an in-band link hot-reset indication. All three are asynchronous to the core clock. The block drives two reset domains:

- an ordinary domain, for state machines and normal registers;
- a sticky domain, for error bits that only a cold reset may clear.

It also drives an output-enable control that holds the chip outputs in a safe state during reset. A role input selects how the hot-reset indication is treated. In endpoint role (`root_mode` = 0) a hot reset resets the ordinary domain. In root role (`root_mode` = 1) the chip issues the hot reset itself, so the indication is ignored.

Every reset output asserts asynchronously, at the moment its source becomes active. Release is synchronous. The release first passes a flop chain of `SYNC_STAGES` flops and then a further stretch of `STRETCH` cycles, both on the core clock. Configuration straps are sampled once, when the synchronized cold reset releases. They are held until the next cold reset, and `strap_capture` pulses for one cycle to mark the capture.

Each reset domain has its own release state machine, `rdc_release`, with these states:

| State | Meaning |
|---|---|
| `REL_HOLD` | Reset held |
| `REL_STRETCH` | Release counting |
| `REL_RUN` | Released |

Its transitions:

- HOLD→STRETCH when the synchronized source reads released; the counter clears.
- STRETCH→STRETCH while counting.
- STRETCH→RUN when the count reaches `STRETCH`−1.
- Any state →HOLD asynchronously when the domain source asserts.

The strap capture machine, `rdc_strap`, has these states:

| State | Meaning |
|---|---|
| `CAP_WAIT` | Waiting for the cold reset to release |
| `CAP_TAKE` | One-cycle capture pulse |
| `CAP_HELD` | Straps frozen |

Its transitions:

- WAIT→TAKE when the synchronized cold reset reads released; the straps load on this edge.
- TAKE→HELD after one cycle.
- HELD→HELD from then on.
- Any state →WAIT asynchronously on a cold reset.

Top module: `rst_domain_ctrl`

## Requirements
- R1: While `cold_rst_n` is low, `core_rst_n`, `sticky_rst_n` and `out_safe_n` are all low. They go low with no clock edge needed.
- R2: With the defaults (`SYNC_STAGES`=2, `STRETCH`=4), a reset output whose sources have all ended is still low after the 6th rising clock edge. It is high after the 7th rising edge.
- R3: A low `warm_rst_n` drives `core_rst_n` low at once. It leaves `sticky_rst_n` high.
- R4: When `root_mode` is 0, a high `hot_rst_req` drives `core_rst_n` low at once. It leaves `sticky_rst_n` high.
- R5: When `root_mode` is 1, `hot_rst_req` has no effect on `core_rst_n`, `sticky_rst_n` or `out_safe_n`.
- R6: When sources overlap, `core_rst_n` is released on the 7th rising edge after the last applicable source ends. Until then it stays low.
- R7: `out_safe_n` is low whenever `core_rst_n` is low. It rises exactly one rising edge after `core_rst_n` rises.
- R8: `strap_q` loads `strap_in` on the 3rd rising edge after `cold_rst_n` rises. `strap_capture` is high for exactly the one cycle that follows that edge.
- R9: A cold reset clears `strap_q` to 0. After capture, `strap_q` does not change on `strap_in` changes, warm resets or hot resets.
- R10: Only `cold_rst_n` can drive `sticky_rst_n` low. Once released, it stays high until the next cold reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| cold_rst_n | input | 1 | Cold platform reset, active low, asynchronous |
| warm_rst_n | input | 1 | Warm reset, active low, asynchronous |
| hot_rst_req | input | 1 | In-band hot-reset indication, active high, asynchronous |
| root_mode | input | 1 | Role select: 0 endpoint, 1 root |
| strap_in | input | STRAP_W | Configuration strap inputs |
| core_rst_n | output | 1 | Ordinary-domain reset, active low |
| sticky_rst_n | output | 1 | Sticky-domain reset, active low |
| out_safe_n | output | 1 | Chip output enable; low holds outputs safe |
| strap_capture | output | 1 | One-cycle pulse when the straps are captured |
| strap_q | output | STRAP_W | Captured strap values |

## Verification
A cold release is driven on its own, with the cycle of each output edge checked. This separates the flop chain from the stretch and the output-enable lag. Warm and endpoint hot resets are each applied alone, which shows which causes reach the sticky domain and the held straps. A hot reset in root role tells role gating apart from plain OR-ing. Overlapping warm and hot pulses, with the hot pulse ending last, show that release counts from the final source. A second cold reset with new strap values shows both the clear and the recapture.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

    typedef enum logic [1:0] {
        REL_HOLD    = 2'd0,
        REL_STRETCH = 2'd1,
        REL_RUN     = 2'd2
    } rel_state_e;

    typedef enum logic [1:0] {
        CAP_WAIT = 2'd0,
        CAP_TAKE = 2'd1,
        CAP_HELD = 2'd2
    } cap_state_e;

    localparam int DOM_CORE   = 0;
    localparam int DOM_STICKY = 1;
    localparam int NUM_DOMS   = 2;

endpackage

// File: rtl/rdc_sync.sv
module rdc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic src_n,
    output logic sync_o
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge src_n) begin
                if (!src_n) chain <= '0;
                else        chain <= 1'b1;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge src_n) begin
                if (!src_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], 1'b1};
            end
        end
    endgenerate

    assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/rdc_release.sv
module rdc_release
    import rdc_pkg::*;
#(
    parameter int STRETCH = 4
) (
    input  logic clk,
    input  logic src_n,
    input  logic sync_i,
    output logic rst_n_o
);

    localparam int CW = (STRETCH > 1) ? $clog2(STRETCH) : 1;
    localparam logic [CW-1:0] LAST = CW'(STRETCH - 1);

    rel_state_e    st, st_nx;
    logic [CW-1:0] cnt, cnt_nx;

    // State register
    always_ff @(posedge clk or negedge src_n) begin
        if (!src_n) begin
            st  <= REL_HOLD;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    // Next-state logic
    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            REL_HOLD: begin
                if (sync_i) begin
                    st_nx  = REL_STRETCH;
                    cnt_nx = '0;
                end
            end
            REL_STRETCH: begin
                if (cnt == LAST) st_nx = REL_RUN;
                else             cnt_nx = cnt + 1'b1;
            end
            REL_RUN: st_nx = REL_RUN;
            default: st_nx = REL_HOLD;
        endcase
    end

    // Outputs
    always_comb begin
        rst_n_o = (st == REL_RUN);
    end

    // The domain may only run while its synchronized source reads released
    assert_release_needs_sync_R2: assert property (
        @(posedge clk) disable iff (!src_n) rst_n_o |-> sync_i
    );

    // Once running, the domain stays released until its source asserts again
    assert_run_is_sticky_R10: assert property (
        @(posedge clk) disable iff (!src_n) rst_n_o |=> rst_n_o
    );

endmodule

// File: rtl/rdc_strap.sv
module rdc_strap
    import rdc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         cold_n,
    input  logic         sync_i,
    input  logic [W-1:0] strap_i,
    output logic [W-1:0] strap_q_o,
    output logic         cap_pulse_o
);

    cap_state_e   st, st_nx;
    logic [W-1:0] hold;
    logic         load;

    assign load = (st == CAP_WAIT) && sync_i;

    // State and holding register
    always_ff @(posedge clk or negedge cold_n) begin
        if (!cold_n) begin
            st   <= CAP_WAIT;
            hold <= '0;
        end else begin
            st <= st_nx;
            if (load) hold <= strap_i;
        end
    end

    // Next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            CAP_WAIT: if (sync_i) st_nx = CAP_TAKE;
            CAP_TAKE: st_nx = CAP_HELD;
            CAP_HELD: st_nx = CAP_HELD;
            default:  st_nx = CAP_WAIT;
        endcase
    end

    // Outputs
    always_comb begin
        cap_pulse_o = (st == CAP_TAKE);
        strap_q_o   = hold;
    end

    assert_straps_frozen_R9: assert property (
        @(posedge clk) disable iff (!cold_n) (st == CAP_HELD) |=> $stable(strap_q_o)
    );

    assert_single_capture_pulse_R8: assert property (
        @(posedge clk) disable iff (!cold_n) cap_pulse_o |=> !cap_pulse_o
    );

endmodule

// File: rtl/rst_domain_ctrl.sv
module rst_domain_ctrl
    import rdc_pkg::*;
#(
    parameter int STRAP_W     = 4,
    parameter int SYNC_STAGES = 2,
    parameter int STRETCH     = 4
) (
    input  logic               clk,
    input  logic               cold_rst_n,
    input  logic               warm_rst_n,
    input  logic               hot_rst_req,
    input  logic               root_mode,
    input  logic [STRAP_W-1:0] strap_in,
    output logic               core_rst_n,
    output logic               sticky_rst_n,
    output logic               out_safe_n,
    output logic               strap_capture,
    output logic [STRAP_W-1:0] strap_q
);

    logic [NUM_DOMS-1:0] src_n;
    logic [NUM_DOMS-1:0] sync_n;
    logic [NUM_DOMS-1:0] dom_rst_n;
    logic                hot_apply;
    logic                safe_q;

    // Hot reset only counts in endpoint role
    assign hot_apply         = hot_rst_req & ~root_mode;
    assign src_n[DOM_CORE]   = cold_rst_n & warm_rst_n & ~hot_apply;
    assign src_n[DOM_STICKY] = cold_rst_n;

    generate
        for (genvar d = 0; d < NUM_DOMS; d++) begin : g_dom
            rdc_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk    (clk),
                .src_n  (src_n[d]),
                .sync_o (sync_n[d])
            );
            rdc_release #(.STRETCH(STRETCH)) u_rel (
                .clk     (clk),
                .src_n   (src_n[d]),
                .sync_i  (sync_n[d]),
                .rst_n_o (dom_rst_n[d])
            );
        end
    endgenerate

    assign core_rst_n   = dom_rst_n[DOM_CORE];
    assign sticky_rst_n = dom_rst_n[DOM_STICKY];

    // Output enable trails the ordinary-domain release by one edge
    always_ff @(posedge clk or negedge src_n[DOM_CORE]) begin
        if (!src_n[DOM_CORE]) safe_q <= 1'b0;
        else                  safe_q <= core_rst_n;
    end
    assign out_safe_n = safe_q;

    rdc_strap #(.W(STRAP_W)) u_strap (
        .clk         (clk),
        .cold_n      (cold_rst_n),
        .sync_i      (sync_n[DOM_STICKY]),
        .strap_i     (strap_in),
        .strap_q_o   (strap_q),
        .cap_pulse_o (strap_capture)
    );

    assert_safe_needs_core_R7: assert property (
        @(posedge clk) disable iff (!src_n[DOM_CORE]) out_safe_n |-> core_rst_n
    );

    assert_safe_lags_core_R7: assert property (
        @(posedge clk) disable iff (!src_n[DOM_CORE]) $rose(out_safe_n) |-> $past(core_rst_n)
    );

    assert_sticky_low_core_low_R10: assert property (
        @(posedge clk) disable iff (!cold_rst_n) !sticky_rst_n |-> !core_rst_n
    );

    assert_root_hot_ignored_R5: assert property (
        @(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
        (root_mode && core_rst_n) |=> (core_rst_n || !root_mode)
    );

endmodule

// File: tb/rst_domain_ctrl_tb.sv
module rst_domain_ctrl_tb;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         cold_rst_n, warm_rst_n, hot_rst_req, root_mode;
    logic [W-1:0] strap_in;
    logic         core_rst_n, sticky_rst_n, out_safe_n, strap_capture;
    logic [W-1:0] strap_q;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk; // 125 MHz

    rst_domain_ctrl #(.STRAP_W(W)) u_dut (
        .clk           (clk),
        .cold_rst_n    (cold_rst_n),
        .warm_rst_n    (warm_rst_n),
        .hot_rst_req   (hot_rst_req),
        .root_mode     (root_mode),
        .strap_in      (strap_in),
        .core_rst_n    (core_rst_n),
        .sticky_rst_n  (sticky_rst_n),
        .out_safe_n    (out_safe_n),
        .strap_capture (strap_capture),
        .strap_q       (strap_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    // Called at the negedge where the last ordinary source ended
    task automatic expect_core_release(input string req);
        edges(6);
        chk({req, " core low after 6 edges"}, core_rst_n, 1'b0);
        chk({req, " R7 safe low"}, out_safe_n, 1'b0);
        edges(1);
        chk({req, " R2 core high after 7 edges"}, core_rst_n, 1'b1);
        chk({req, " R7 safe still low"}, out_safe_n, 1'b0);
        edges(1);
        chk({req, " R7 safe high one edge later"}, out_safe_n, 1'b1);
    endtask

    task automatic t_reset_state;
        edges(3);
        chk("R1 core in reset", core_rst_n, 1'b0);
        chk("R1 sticky in reset", sticky_rst_n, 1'b0);
        chk("R1 safe low", out_safe_n, 1'b0);
        chk("R9 straps clear", strap_q, '0);
        chk("R8 no pulse", strap_capture, 1'b0);
    endtask

    task automatic t_cold_release(input logic [W-1:0] val);
        strap_in   = val;
        cold_rst_n = 1'b1;
        edges(2);
        chk("R8 no pulse before capture", strap_capture, 1'b0);
        edges(1);
        chk("R8 capture pulse", strap_capture, 1'b1);
        chk("R8 straps loaded", strap_q, val);
        edges(1);
        chk("R8 pulse one cycle", strap_capture, 1'b0);
        edges(2);
        chk("R2 sticky low after 6", sticky_rst_n, 1'b0);
        chk("R2 core low after 6", core_rst_n, 1'b0);
        edges(1);
        chk("R2 sticky high after 7", sticky_rst_n, 1'b1);
        chk("R2 core high after 7", core_rst_n, 1'b1);
        chk("R7 safe lags", out_safe_n, 1'b0);
        edges(1);
        chk("R7 safe high", out_safe_n, 1'b1);
        strap_in = ~val;
        edges(3);
        chk("R9 straps frozen vs input", strap_q, val);
    endtask

    task automatic t_warm(input logic [W-1:0] held);
        warm_rst_n = 1'b0;
        #1;
        chk("R3 core async low", core_rst_n, 1'b0);
        chk("R7 safe async low", out_safe_n, 1'b0);
        chk("R3 sticky kept", sticky_rst_n, 1'b1);
        edges(4);
        chk("R10 sticky kept in warm", sticky_rst_n, 1'b1);
        warm_rst_n = 1'b1;
        expect_core_release("R3 warm");
        chk("R9 straps kept by warm", strap_q, held);
        chk("R10 sticky after warm", sticky_rst_n, 1'b1);
    endtask

    task automatic t_hot_endpoint(input logic [W-1:0] held);
        root_mode   = 1'b0;
        hot_rst_req = 1'b1;
        #1;
        chk("R4 core async low", core_rst_n, 1'b0);
        chk("R4 sticky kept", sticky_rst_n, 1'b1);
        edges(4);
        hot_rst_req = 1'b0;
        expect_core_release("R4 hot");
        chk("R9 straps kept by hot", strap_q, held);
    endtask

    task automatic t_hot_root;
        root_mode = 1'b1;
        edges(1);
        hot_rst_req = 1'b1;
        #1;
        chk("R5 core unaffected", core_rst_n, 1'b1);
        for (int i = 0; i < 10; i++) begin
            edges(1);
            chk("R5 core unaffected", core_rst_n, 1'b1);
            chk("R5 sticky unaffected", sticky_rst_n, 1'b1);
            chk("R5 safe unaffected", out_safe_n, 1'b1);
        end
        hot_rst_req = 1'b0;
        edges(1);
        root_mode = 1'b0;
        edges(1);
        chk("R5 core after root hot", core_rst_n, 1'b1);
    endtask

    task automatic t_overlap;
        warm_rst_n  = 1'b0;
        edges(2);
        hot_rst_req = 1'b1;
        edges(2);
        warm_rst_n  = 1'b1;
        edges(9);
        chk("R6 core held by hot", core_rst_n, 1'b0);
        chk("R6 safe held", out_safe_n, 1'b0);
        hot_rst_req = 1'b0;
        expect_core_release("R6 overlap");
    endtask

    task automatic t_cold_again;
        cold_rst_n = 1'b0;
        #1;
        chk("R1 core async on cold", core_rst_n, 1'b0);
        chk("R10 sticky async on cold", sticky_rst_n, 1'b0);
        chk("R1 safe async on cold", out_safe_n, 1'b0);
        chk("R9 straps cleared by cold", strap_q, '0);
        edges(3);
        t_cold_release(4'h5);
    endtask

    initial begin
        cold_rst_n  = 1'b0;
        warm_rst_n  = 1'b1;
        hot_rst_req = 1'b0;
        root_mode   = 1'b0;
        strap_in    = 4'hA;
        @(negedge clk);
        t_reset_state();
        t_cold_release(4'hA);
        t_warm(4'hA);
        t_hot_endpoint(4'hA);
        t_hot_root();
        t_overlap();
        t_cold_again();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule